// File: doc/BRIEF.md
# Asynchronous byte-wide SRAM access controller

This block connects an on-chip request port to an external asynchronous static RAM. The RAM has a 17-bit address, an 8-bit data bus and two chip selects of opposite polarity. It also has an active-low write strobe and an active-low output enable. Each request is one read or one write, accepted through a valid/ready handshake. The controller turns it into a fixed sequence of strobe phases. Every phase length is a whole number of clock cycles, derived from nanosecond timing parameters and the clock period. Reads return the captured byte together with a one-cycle done pulse. Writes also report a done pulse.

Writes use the write strobe to control the cycle. The output enable stays high for the whole write. The controller turns on its own data drivers only after the RAM's output turn-off time has elapsed. Whenever no access is in flight, both chip selects are held inactive, so the RAM sits deselected in its low-current standby state. The data pins are split into an output value, an output enable and an input value, so that the pad ring can build the tri-state buffer.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `ram_s1_no`=1, `ram_s2_o`=0, `ram_w_no`=1, `ram_oe_no`=1, `ram_dq_oe_o`=0, `req_ready_o`=1 and `rsp_done_o`=0.
- R2: Whenever `req_ready_o` is high, the RAM is deselected (`ram_s1_no`=1, `ram_s2_o`=0). The two selects always switch together.
- R3: Phase lengths use cyc(t)=max(1, ceil(t/CLK_PERIOD_NS)). Count cycles k from the first cycle after acceptance (k=0). For a write, the RAM is selected for k=0..WEND, where WEND=AS+WLOW and AS=cyc(T_AS_NS). The write strobe is low for exactly WLOW cycles starting at k=AS. WLOW=max(cyc(T_WP_NS), TURN+DS, cyc(T_CW_NS)-AS). The address equals the accepted address and holds steady throughout the select window, even if the request inputs change.
- R4: During a write, `ram_oe_no` stays 1. `ram_dq_oe_o` is 1 exactly for k=AS+TURN..WEND, where TURN=cyc(T_BUS_OFF_NS), and `ram_dq_o` then carries the accepted write byte.
- R5: During a write, the data drivers are on for at least DS=cyc(T_DS_NS) cycles before the write strobe rises.
- R6: For a read, the RAM is selected for k=0..CAP with the write strobe high and the drivers off. CAP=max(cyc(T_AA_NS)-1, cyc(T_OE_NS)). The output enable is low exactly for k=1..CAP.
- R7: The read byte is the RAM data present in cycle k=CAP. It appears on `rsp_rdata_o` at k=CAP+1 and holds until the next read captures.
- R8: `req_ready_o` is low from k=0 while k < TOTAL. TOTAL is max(cyc(T_WC_NS), WEND+1) for writes and max(cyc(T_RC_NS), CAP+1) for reads. A request held valid during that time is not started early.
- R9: The controller's drivers and the RAM's output enable are never active in the same cycle. At least one cycle with both off separates driver release from output-enable assertion, including on a write directly followed by a read.
- R10: `rsp_done_o` pulses high for exactly one cycle per access, at k=WEND+1 for writes and at k=CAP+1 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Request address |
| req_wdata_i | input | 8 | Write byte |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Captured read byte |
| ram_addr_o | output | 17 | RAM address |
| ram_s1_no | output | 1 | RAM chip select, active low |
| ram_s2_o | output | 1 | RAM chip select, active high |
| ram_w_no | output | 1 | RAM write strobe, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_dq_o | output | 8 | Data to the pad driver |
| ram_dq_oe_o | output | 1 | Pad driver enable |
| ram_dq_i | input | 8 | Data from the pad |

## Verification
With a 4 ns clock, the defaults give AS=1, TURN=7, DS=8, WLOW=16, WEND=17, CAP=17 and TOTAL=18. Every strobe is a register loaded from the next-state counter, so the value for cycle k appears right after the accepting edge plus k clocks. The bench records one sample per cycle at the falling edge, starting with the cycle after acceptance, and compares the indices of the first and last active cycle of each strobe against the formulas. Done and read data are checked in the k=CAP+1 or k=WEND+1 sample, which is also where ready must return. A monitor checks every cycle for driver/output-enable overlap and for the deselected idle state.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceil(t/per), never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned per_ns);
    return umax(1, (t_ns + per_ns - 1) / per_ns);
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned WR_END = 17,
  parameter int unsigned WR_TOT = 18,
  parameter int unsigned RD_CAP = 17,
  parameter int unsigned RD_TOT = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             busy_d_o,
  output logic             we_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             cap_en_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_TOT - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_TOT - 1);
  localparam logic [CNT_W-1:0] WR_END_C = CNT_W'(WR_END);
  localparam logic [CNT_W-1:0] RD_CAP_C = CNT_W'(RD_CAP);

  logic             busy_q, we_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last     = we_q ? WR_LAST : RD_LAST;
  assign accept_o = req_valid_i && !busy_q;
  assign ready_o  = !busy_q;
  assign cap_en_o = busy_q && !we_q && (cnt_q == RD_CAP_C);
  assign done_o   = done_q;

  always_comb begin
    busy_d_o = busy_q;
    we_d_o   = we_q;
    cnt_d_o  = cnt_q;
    if (accept_o) begin
      busy_d_o = 1'b1;
      we_d_o   = req_we_i;
      cnt_d_o  = '0;
    end else if (busy_q) begin
      if (cnt_q == last) begin
        busy_d_o = 1'b0;
        cnt_d_o  = '0;
      end else begin
        cnt_d_o = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d_o;
      we_q   <= we_d_o;
      cnt_q  <= cnt_d_o;
      done_q <= busy_q && (cnt_q == (we_q ? WR_END_C : RD_CAP_C));
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/sram_ctrl_strobe.sv
module sram_ctrl_strobe #(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned AS     = 1,
  parameter int unsigned WLOW   = 16,
  parameter int unsigned TURN   = 7,
  parameter int unsigned WR_END = 17,
  parameter int unsigned RD_CAP = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_d_i,
  input  logic             we_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic             s1_no,
  output logic             s2_o,
  output logic             w_no,
  output logic             oe_no,
  output logic             dq_oe_o
);

  localparam logic [CNT_W-1:0] W_ON   = CNT_W'(AS);
  localparam logic [CNT_W-1:0] W_OFF  = CNT_W'(AS + WLOW);
  localparam logic [CNT_W-1:0] DQ_ON  = CNT_W'(AS + TURN);
  localparam logic [CNT_W-1:0] WEND_C = CNT_W'(WR_END);
  localparam logic [CNT_W-1:0] CAP_C  = CNT_W'(RD_CAP);

  logic sel_n, w_n, oe_n, dq_n;

  // strobes are decoded from next-state so every pin is a flop output
  always_comb begin
    sel_n = 1'b0;
    w_n   = 1'b0;
    oe_n  = 1'b0;
    dq_n  = 1'b0;
    if (busy_d_i) begin
      if (we_d_i) begin
        sel_n = (cnt_d_i <= WEND_C);
        w_n   = (cnt_d_i >= W_ON) && (cnt_d_i < W_OFF);
        dq_n  = (cnt_d_i >= DQ_ON) && (cnt_d_i <= WEND_C);
      end else begin
        sel_n = (cnt_d_i <= CAP_C);
        oe_n  = (cnt_d_i >= CNT_W'(1)) && (cnt_d_i <= CAP_C);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_no   <= 1'b1;
      s2_o    <= 1'b0;
      w_no    <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      s1_no   <= !sel_n;
      s2_o    <= sel_n;
      w_no    <= !w_n;
      oe_no   <= !oe_n;
      dq_oe_o <= dq_n;
    end
  end

  // R2
  sel_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_no == !s2_o);

  // R3
  w_in_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_no |-> (!s1_no && s2_o));

  // R4
  no_oe_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!w_no && !oe_no));

  // R9
  no_bus_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe_o && !oe_no));

  // R9
  release_before_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_no) |-> !$past(dq_oe_o));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
      end
      if (cap_en_i) rdata_o <= ram_dq_i;
    end
  end

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cap_en_i) |-> $stable(rdata_o));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_OE_NS       = 35,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_CW_NS       = 65,
  parameter int unsigned T_DS_NS       = 30,
  parameter int unsigned T_BUS_OFF_NS  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_s1_no,
  output logic              ram_s2_o,
  output logic              ram_w_no,
  output logic              ram_oe_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);

  localparam int unsigned AS     = ns2cyc(T_AS_NS, CLK_PERIOD_NS);
  localparam int unsigned TURN   = ns2cyc(T_BUS_OFF_NS, CLK_PERIOD_NS);
  localparam int unsigned DS     = ns2cyc(T_DS_NS, CLK_PERIOD_NS);
  localparam int unsigned CW     = ns2cyc(T_CW_NS, CLK_PERIOD_NS);
  localparam int unsigned WLOW   = umax(umax(ns2cyc(T_WP_NS, CLK_PERIOD_NS), TURN + DS),
                                        (CW > AS) ? CW - AS : 1);
  localparam int unsigned WR_END = AS + WLOW;
  localparam int unsigned WR_TOT = umax(ns2cyc(T_WC_NS, CLK_PERIOD_NS), WR_END + 1);
  localparam int unsigned RD_CAP = umax(ns2cyc(T_AA_NS, CLK_PERIOD_NS) - 1,
                                        ns2cyc(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_TOT = umax(ns2cyc(T_RC_NS, CLK_PERIOD_NS), RD_CAP + 1);
  localparam int unsigned CNT_W  = $clog2(umax(WR_TOT, RD_TOT) + 1);

  logic             accept, busy_d, we_d, cap_en;
  logic [CNT_W-1:0] cnt_d;

  sram_ctrl_seq #(
    .CNT_W(CNT_W), .WR_END(WR_END), .WR_TOT(WR_TOT), .RD_CAP(RD_CAP), .RD_TOT(RD_TOT)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .ready_o    (req_ready_o),
    .accept_o   (accept),
    .busy_d_o   (busy_d),
    .we_d_o     (we_d),
    .cnt_d_o    (cnt_d),
    .cap_en_o   (cap_en),
    .done_o     (rsp_done_o)
  );

  sram_ctrl_strobe #(
    .CNT_W(CNT_W), .AS(AS), .WLOW(WLOW), .TURN(TURN), .WR_END(WR_END), .RD_CAP(RD_CAP)
  ) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_d_i(busy_d),
    .we_d_i  (we_d),
    .cnt_d_i (cnt_d),
    .s1_no   (ram_s1_no),
    .s2_o    (ram_s2_o),
    .w_no    (ram_w_no),
    .oe_no   (ram_oe_no),
    .dq_oe_o (ram_dq_oe_o)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .cap_en_i   (cap_en),
    .ram_dq_i   (ram_dq_i),
    .addr_o     (ram_addr_o),
    .wdata_o    (ram_dq_o),
    .rdata_o    (rsp_rdata_o)
  );

  // R3
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_s2_o && $past(ram_s2_o)) |-> $stable(ram_addr_o));

  // R2
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ram_s1_no && !ram_s2_o));

endmodule

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;

  localparam int P  = 4;
  localparam int NS = 19;

  function automatic int cyc(input int t);
    int c;
    c = (t + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_AS   = cyc(0);
  localparam int E_TURN = cyc(25);
  localparam int E_DS   = cyc(30);
  localparam int E_WLOW = mx(mx(cyc(55), E_TURN + E_DS), cyc(65) - E_AS);
  localparam int E_WEND = E_AS + E_WLOW;
  localparam int E_WTOT = mx(cyc(70), E_WEND + 1);
  localparam int E_CAP  = mx(cyc(70) - 1, cyc(35));
  localparam int E_RTOT = mx(cyc(70), E_CAP + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, done, s1_n, s2, w_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [16:0] addr;

  int n_chk = 0, n_fail = 0, r2_bad = 0, r9_bad = 0;
  logic prev_dq_oe = 1'b0;
  logic [7:0] mem [256];

  logic        t_sel[NS], t_w[NS], t_oe[NS], t_dq[NS], t_rdy[NS], t_done[NS];
  logic [16:0] t_addr[NS];
  logic [7:0]  t_dqo[NS];
  logic [7:0]  t_rd;

  always #2 clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(done), .rsp_rdata_o(rdata),
    .ram_addr_o(addr), .ram_s1_no(s1_n), .ram_s2_o(s2), .ram_w_no(w_n),
    .ram_oe_no(oe_n), .ram_dq_o(dq_o), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  // RAM model
  initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  always @(posedge w_n) if (!s1_n && s2 && dq_oe) mem[addr[7:0]] = dq_o;
  always_comb dq_i = (!s1_n && s2 && w_n && !oe_n) ? mem[addr[7:0]] : 8'h00;

  // cycle monitor for R2 and R9
  always @(negedge clk) if (rst_n) begin
    if (ready && (!s1_n || s2)) r2_bad++;
    if (dq_oe && !oe_n) r9_bad++;
    if (prev_dq_oe && !oe_n) r9_bad++;
    prev_dq_oe = dq_oe;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic record();
    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_addr  = ~req_addr;
        req_wdata = ~req_wdata;
      end
      t_sel[k] = !s1_n && s2; t_w[k] = !w_n; t_oe[k] = !oe_n; t_dq[k] = dq_oe;
      t_rdy[k] = ready; t_done[k] = done; t_addr[k] = addr; t_dqo[k] = dq_o;
      if (k == NS - 1) t_rd = rdata;
    end
  endtask

  function automatic int first1(input logic v[NS]);
    for (int k = 0; k < NS; k++) if (v[k]) return k;
    return -1;
  endfunction
  function automatic int last1(input logic v[NS]);
    for (int k = NS - 1; k >= 0; k--) if (v[k]) return k;
    return -1;
  endfunction
  function automatic int cnt1(input logic v[NS]);
    int c = 0;
    for (int k = 0; k < NS; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic check_common(input int end_k, input int tot, input int done_k);
    check("R3", "select first", first1(t_sel), 0);
    check("R3", "select last", last1(t_sel), end_k);
    check("R8", "ready low cycles", NS - cnt1(t_rdy), tot);
    check("R8", "ready back", int'(t_rdy[tot]), 1);
    check("R10", "done count", cnt1(t_done), 1);
    check("R10", "done cycle", first1(t_done), done_k);
  endtask

  // called at a falling edge with ready high
  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int bad_a = 0, bad_d = 0, setup = 0;
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    record();
    for (int k = 0; k <= E_WEND; k++) if (t_addr[k] != a) bad_a++;
    for (int k = 0; k < NS; k++) begin
      if (t_dq[k] && t_dqo[k] != d) bad_d++;
      if (t_dq[k] && t_w[k]) setup++;
    end
    check_common(E_WEND, E_WTOT, E_WEND + 1);
    check("R3", "W low cycles", cnt1(t_w), E_WLOW);
    check("R3", "W first low", first1(t_w), E_AS);
    check("R3", "address held", bad_a, 0);
    check("R4", "OE low in write", cnt1(t_oe), 0);
    check("R4", "drivers on", first1(t_dq), E_AS + E_TURN);
    check("R4", "drivers off", last1(t_dq), E_WEND);
    check("R4", "bus data", bad_d, 0);
    check("R5", "setup ok", int'(setup >= E_DS), 1);
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input bit hold_wr,
                         input logic [16:0] wa, input logic [7:0] wd);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk);
    #1;
    if (hold_wr) begin
      req_we = 1'b1; req_addr = ~wa; req_wdata = ~wd;
    end else req_valid = 1'b0;
    record();
    check_common(E_CAP, E_RTOT, E_CAP + 1);
    check("R6", "W low in read", cnt1(t_w), 0);
    check("R6", "drivers in read", cnt1(t_dq), 0);
    check("R6", "OE first", first1(t_oe), 1);
    check("R6", "OE last", last1(t_oe), E_CAP);
    check("R6", "OE count", cnt1(t_oe), E_CAP);
    check("R7", "read data", int'(t_rd), int'(exp));
    if (hold_wr) check("R8", "held request not started", int'(t_addr[E_CAP]), int'(a));
  endtask

  initial begin
    #(P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "S1 in reset", int'(s1_n), 1);
    check("R1", "S2 in reset", int'(s2), 0);
    check("R1", "W in reset", int'(w_n), 1);
    check("R1", "OE in reset", int'(oe_n), 1);
    check("R1", "drivers in reset", int'(dq_oe), 0);
    check("R1", "ready in reset", int'(ready), 1);
    check("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "S1 after reset", int'(s1_n), 1);
    check("R1", "W after reset", int'(w_n), 1);
    do_read(17'h00010, 8'hFF, 1'b0, '0, '0);
    do_write(17'h12345, 8'hA5);
    do_write(17'h000FF, 8'h3C);
    do_write(17'h1FF00, 8'h00);
    // write directly followed by read (R9)
    do_read(17'h12345, 8'hA5, 1'b0, '0, '0);
    do_read(17'h000FF, 8'h3C, 1'b0, '0, '0);
    // read with a write request held valid throughout (R8)
    do_read(17'h1FF00, 8'h00, 1'b1, 17'h0AB77, 8'h5A);
    do_write(17'h0AB77, 8'h5A);
    do_read(17'h0AB77, 8'h5A, 1'b0, '0, '0);
    repeat (4) @(negedge clk);
    check("R2", "idle select violations", r2_bad, 0);
    check("R9", "driver/OE overlap", r9_bad, 0);
    finish_run();
  end

endmodule